// File: doc/BRIEF.md
# Sequential Matrix-Multiply Engine

This block forms the product of two square integer matrices. It uses one multiplier and one accumulator, and a small controller runs them over a nested loop. With the default parameters the matrices are 8x8. Both operand matrices arrive one word per cycle on a single input port. The finished product leaves one word per cycle on a single output port. A level-sensitive start input and a done output form the handshake with the surrounding logic.

A single step counter drives every phase. It runs 0..63 while each operand matrix is stored, then 0..511 during the multiply-accumulate loop, then 0..63 again while the results are streamed out. During the compute phase its bits are read as three index fields: column j in the top bits, row i in the middle bits and inner index k in the low bits. Each multiply-accumulate step passes through the states `S_RD_A` (present the A address), `S_LD_A` (latch A and present the B address), `S_LD_B` (latch B), `S_MUL` (latch the product), `S_ACC` (add it to the sum) and `S_INC` (advance the counter). When k is at its last value, `S_STORE` is inserted after `S_ACC` to write the sum into the result store and clear it.

The states and their transitions:

- `S_IDLE` clears the counter and the sum, and goes to `S_LOAD_A` when start is 1.
- `S_LOAD_A` goes to `S_LOAD_B` after 64 words, and `S_LOAD_B` goes to `S_RD_A` after 64 words. The counter is cleared at each of these changes.
- `S_RD_A` goes to `S_LD_A`, then `S_LD_B`, then `S_MUL`, then `S_ACC`.
- `S_ACC` goes to `S_STORE` when k is 7 and to `S_INC` otherwise. `S_STORE` goes to `S_INC`.
- `S_INC` goes to `S_OUT` when the counter is 511, clearing it. Otherwise it goes back to `S_RD_A`.
- `S_OUT` goes to `S_FIN` after 64 reads.
- `S_FIN` raises done and goes to `S_IDLE` once start is 0.

Top module: `matmul_seq`

## Requirements
- R1: After a synchronous active-high reset, done is 0 and dout is 0, and the block is idle.
- R2: Once start is sampled 1 while idle, the next 64 din words are stored as matrix A in row-major order (word 8*row+col). The 64 words after those are stored as matrix B in the same order, one word per clock.
- R3: Each result is C[i][j] = sum over k of A[i][k]*B[k][j]. The operands are 16-bit signed. Products and sums are 32-bit two's complement and wrap on overflow. A result is written only when the k field of the counter is 7.
- R4: Results leave on dout one per clock in row-major order (element 8*i+j). The last element, C[7][7], is on dout in the first cycle that done is 1.
- R5: done first goes high exactly 3328 clock edges after the edge that accepted start. This is 128 load cycles, plus 512 steps of 6 cycles, plus 64 store cycles, plus 64 output cycles.
- R6: done stays 1 while start stays 1. After the first edge at which start is 0, done is 0.
- R7: Changes of the start level during load, compute or output change neither the results nor the timing.
- R8: Every run begins with a cleared accumulator, and the sum is zero in the cycle after each result write. Back-to-back runs therefore give independent results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Level request to begin a run; must return to 0 to release done |
| din | input | DW (16) | Serial operand word, A then B, row-major |
| done | output | 1 | High after the last result has been presented, until start is 0 |
| dout | output | PW (32) | Serial result word, row-major |

## Verification
The bench sweeps whole matrices through the block:

- an identity times a ramp, so that any swapped i, j or k field or any wrong address formula misplaces a visible value;
- pseudo-random signed data, which exposes sign-extension mistakes;
- extreme operands whose dot products wrap past 32 bits, where a wrong accumulator width shows up.

A run that follows another catches a sum that is not cleared between results or between runs, because every element of the second product would be offset. Start is toggled in the middle of compute to catch a controller that samples start outside idle and the done state. The bench also counts the exact edge on which done rises: an extra or missing state in the step sequence moves it by hundreds of cycles.

// File: rtl/matmul_pkg.sv
package matmul_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD_A,
        S_LOAD_B,
        S_RD_A,
        S_LD_A,
        S_LD_B,
        S_MUL,
        S_ACC,
        S_STORE,
        S_INC,
        S_OUT,
        S_FIN
    } mm_state_e;
endpackage

// File: rtl/mm_regfile.sv
module mm_regfile #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/mm_mac.sv
module mm_mac #(
    parameter int DW = 16,
    parameter int PW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 a_ld,
    input  logic signed [DW-1:0] a_in,
    input  logic                 b_ld,
    input  logic signed [DW-1:0] b_in,
    input  logic                 p_ld,
    input  logic                 sum_ld,
    input  logic                 sum_clr,
    output logic signed [PW-1:0] sum
);
    logic signed [DW-1:0] op_a, op_b;
    logic signed [PW-1:0] prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a <= '0;
            op_b <= '0;
            prod <= '0;
            sum  <= '0;
        end else begin
            if (a_ld) op_a <= a_in;
            if (b_ld) op_b <= b_in;
            if (p_ld) prod <= PW'(op_a) * PW'(op_b);
            if (sum_clr)     sum <= '0;
            else if (sum_ld) sum <= sum + prod;
        end
    end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import matmul_pkg::*;
#(
    parameter int N    = 8,
    localparam int IW  = $clog2(N),
    localparam int AW  = 2 * IW,
    localparam int CW  = 3 * IW,
    localparam int TILE  = N * N,
    localparam int STEPS = N * N * N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output mm_state_e     state,
    output logic [CW-1:0] cnt,
    output logic          rfa_we,
    output logic          rfb_we,
    output logic [AW-1:0] ld_addr,
    output logic          rfa_re,
    output logic [AW-1:0] a_raddr,
    output logic          rfb_re,
    output logic [AW-1:0] b_raddr,
    output logic          rfc_we,
    output logic [AW-1:0] c_waddr,
    output logic          rfc_re,
    output logic [AW-1:0] c_raddr,
    output logic          a_ld,
    output logic          b_ld,
    output logic          p_ld,
    output logic          sum_ld,
    output logic          sum_clr,
    output logic          done
);
    mm_state_e nxt;
    logic cnt_clr, cnt_inc;
    logic eq_tile, eq_last;
    logic [IW-1:0] idx_i, idx_j, idx_k;

    assign idx_k = cnt[IW-1:0];
    assign idx_i = cnt[2*IW-1:IW];
    assign idx_j = cnt[3*IW-1:2*IW];

    // terminal-count comparators
    assign eq_tile = (cnt == CW'(TILE - 1));
    assign eq_last = (cnt == CW'(STEPS - 1));

    assign ld_addr = cnt[AW-1:0];
    assign c_raddr = cnt[AW-1:0];
    assign a_raddr = {idx_i, idx_k};
    assign b_raddr = {idx_k, idx_j};
    assign c_waddr = {idx_i, idx_j};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (cnt_clr)      cnt <= '0;
            else if (cnt_inc) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        rfa_we  = 1'b0;
        rfb_we  = 1'b0;
        rfa_re  = 1'b0;
        rfb_re  = 1'b0;
        rfc_we  = 1'b0;
        rfc_re  = 1'b0;
        a_ld    = 1'b0;
        b_ld    = 1'b0;
        p_ld    = 1'b0;
        sum_ld  = 1'b0;
        sum_clr = 1'b0;
        done    = 1'b0;
        unique case (state)
            S_IDLE: begin
                cnt_clr = 1'b1;
                sum_clr = 1'b1;
                if (start) nxt = S_LOAD_A;
            end
            S_LOAD_A: begin
                rfa_we = 1'b1;
                if (eq_tile) begin
                    cnt_clr = 1'b1;
                    nxt     = S_LOAD_B;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            S_LOAD_B: begin
                rfb_we = 1'b1;
                if (eq_tile) begin
                    cnt_clr = 1'b1;
                    nxt     = S_RD_A;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            S_RD_A: begin
                rfa_re = 1'b1;
                nxt    = S_LD_A;
            end
            S_LD_A: begin
                a_ld   = 1'b1;
                rfb_re = 1'b1;
                nxt    = S_LD_B;
            end
            S_LD_B: begin
                b_ld = 1'b1;
                nxt  = S_MUL;
            end
            S_MUL: begin
                p_ld = 1'b1;
                nxt  = S_ACC;
            end
            S_ACC: begin
                sum_ld = 1'b1;
                nxt    = (idx_k == IW'(N - 1)) ? S_STORE : S_INC;
            end
            S_STORE: begin
                rfc_we  = 1'b1;
                sum_clr = 1'b1;
                nxt     = S_INC;
            end
            S_INC: begin
                if (eq_last) begin
                    cnt_clr = 1'b1;
                    nxt     = S_OUT;
                end else begin
                    cnt_inc = 1'b1;
                    nxt     = S_RD_A;
                end
            end
            S_OUT: begin
                rfc_re = 1'b1;
                if (eq_tile) begin
                    cnt_clr = 1'b1;
                    nxt     = S_FIN;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            S_FIN: begin
                done = 1'b1;
                if (!start) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/matmul_seq.sv
module matmul_seq
    import matmul_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 16,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] din,
    output logic          done,
    output logic [PW-1:0] dout
);
    localparam int IW   = $clog2(N);
    localparam int AW   = 2 * IW;
    localparam int CW   = 3 * IW;
    localparam int TILE = N * N;

    mm_state_e     state;
    logic [CW-1:0] cnt;
    logic          rfa_we, rfb_we, rfa_re, rfb_re, rfc_we, rfc_re;
    logic [AW-1:0] ld_addr, a_raddr, b_raddr, c_waddr, c_raddr;
    logic          a_ld, b_ld, p_ld, sum_ld, sum_clr;
    logic [DW-1:0] a_q, b_q;
    logic signed [PW-1:0] sum;

    mm_ctrl #(.N(N)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .state(state), .cnt(cnt),
        .rfa_we(rfa_we), .rfb_we(rfb_we), .ld_addr(ld_addr),
        .rfa_re(rfa_re), .a_raddr(a_raddr),
        .rfb_re(rfb_re), .b_raddr(b_raddr),
        .rfc_we(rfc_we), .c_waddr(c_waddr),
        .rfc_re(rfc_re), .c_raddr(c_raddr),
        .a_ld(a_ld), .b_ld(b_ld), .p_ld(p_ld),
        .sum_ld(sum_ld), .sum_clr(sum_clr), .done(done)
    );

    mm_regfile #(.DEPTH(TILE), .W(DW)) u_rfa (
        .clk(clk), .rst(rst), .we(rfa_we), .waddr(ld_addr), .wdata(din),
        .re(rfa_re), .raddr(a_raddr), .rdata(a_q)
    );

    mm_regfile #(.DEPTH(TILE), .W(DW)) u_rfb (
        .clk(clk), .rst(rst), .we(rfb_we), .waddr(ld_addr), .wdata(din),
        .re(rfb_re), .raddr(b_raddr), .rdata(b_q)
    );

    mm_regfile #(.DEPTH(TILE), .W(PW)) u_rfc (
        .clk(clk), .rst(rst), .we(rfc_we), .waddr(c_waddr), .wdata(sum),
        .re(rfc_re), .raddr(c_raddr), .rdata(dout)
    );

    mm_mac #(.DW(DW), .PW(PW)) u_mac (
        .clk(clk), .rst(rst),
        .a_ld(a_ld), .a_in(a_q),
        .b_ld(b_ld), .b_in(b_q),
        .p_ld(p_ld), .sum_ld(sum_ld), .sum_clr(sum_clr),
        .sum(sum)
    );
endmodule

// File: rtl/mm_check.sv
module mm_check
    import matmul_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 32,
    localparam int IW = $clog2(N),
    localparam int CW = 3 * IW
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input mm_state_e     state,
    input logic [CW-1:0] cnt,
    input logic          rfa_we,
    input logic          rfb_we,
    input logic          rfc_we,
    input logic [PW-1:0] sum
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> !done);

    assert_b_follows_a_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rfa_we) |-> rfb_we);

    assert_store_at_k_last_R3: assert property (@(posedge clk) disable iff (rst)
        rfc_we |-> (cnt[IW-1:0] == IW'(N - 1)));

    assert_done_after_output_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state) == S_OUT);

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> done);

    assert_done_release_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    assert_sum_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        rfc_we |=> (sum == '0));
endmodule

bind matmul_seq mm_check #(.N(N), .PW(PW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .state(state), .cnt(cnt),
    .rfa_we(rfa_we), .rfb_we(rfb_we), .rfc_we(rfc_we),
    .sum(sum)
);

// File: tb/test_matmul_seq.sv
`timescale 1ns/1ps
module test_matmul_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] din = '0;
    logic        done;
    logic [31:0] dout;

    int ma [64];
    int mb [64];
    int exp_c [64];
    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    matmul_seq i_matmul_seq (
        .clk(clk), .rst(rst), .start(start), .din(din),
        .done(done), .dout(dout)
    );

    task automatic check(input string req, input longint got, input longint want);
        n_tests++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic compute_expected();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                int acc = 0;
                for (int k = 0; k < 8; k++) acc += ma[8*r+k] * mb[8*k+c];
                exp_c[8*r+c] = acc;
            end
    endtask

    task automatic fill(input int mode);
        int x = 12345;
        logic signed [15:0] t;
        for (int m = 0; m < 64; m++) begin
            case (mode)
                0: begin
                    ma[m] = ((m / 8) == (m % 8)) ? 1 : 0;
                    mb[m] = m * 37 - 1000;
                end
                1: begin
                    x = x * 1103515245 + 12345;
                    t = x[23:8];
                    ma[m] = int'(t);
                    x = x * 1103515245 + 12345;
                    t = x[23:8];
                    mb[m] = int'(t);
                end
                default: begin
                    ma[m] = -32768;
                    mb[m] = (m % 2 == 0) ? 32767 : -32768;
                end
            endcase
        end
        compute_expected();
    endtask

    task automatic do_run(input bit toggle_start, input string tag);
        int hist [64];
        int cyc = -1;
        bit seen = 1'b0;
        bit early = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        for (int m = 0; m < 128; m++) begin
            @(negedge clk);
            cyc++;
            if (done) early = 1'b1;
            din = (m < 64) ? 16'(ma[m]) : 16'(mb[m-64]);
        end
        while (!seen && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            hist[cyc % 64] = int'(dout);
            if (done) seen = 1'b1;
            if (toggle_start) begin
                if (cyc == 200)  start = 1'b0;
                if (cyc == 1500) start = 1'b1;
                if (cyc == 2900) start = 1'b0;
                if (cyc == 3290) start = 1'b1;
            end
        end
        check({"R5 no early done ", tag}, early, 0);
        if (!seen) begin
            check({"R5 watchdog done never rose ", tag}, 0, 1);
        end else begin
            // R5 (and R7 for toggled run): exact edge count
            check({"R5 R7 done edge ", tag}, cyc, 3328);
            for (int n = 0; n < 64; n++)
                check($sformatf("R2 R3 R4 R7 element %0d %s", n, tag),
                      hist[(cyc - 63 + n) % 64], exp_c[n]);
            for (int h = 0; h < 3; h++) begin
                @(negedge clk);
                check({"R6 done held ", tag}, done, 1);
            end
            start = 1'b0;
            @(negedge clk);
            check({"R6 done released ", tag}, done, 0);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", done, 0);
        check("R1 dout after reset", dout, 0);

        fill(0);
        do_run(1'b0, "identity");
        fill(1);
        // R8: back-to-back run with different data must not carry the old sum
        do_run(1'b0, "R8 lcg");
        fill(2);
        do_run(1'b0, "R3 wrap");
        fill(1);
        do_run(1'b1, "R7 toggled start");
        report();
        $finish;
    end
endmodule